// File: doc/BRIEF.md
# DMA Channel Register Front-End

This block sits between a 32-bit register bus and a bank of DMA channel engines that are arranged in receive/transmit pairs. It decodes each bus access. A write to a channel register becomes a one-cycle write strobe aimed at exactly one channel, together with a register index and the write data. Writes to the global area update the block's own state: an address-width control bit, a per-channel completion status vector and a per-channel interrupt enable vector.

Each channel engine reports the end of a transfer with a single-cycle done pulse. The pulse sets that channel's status bit. Software reads the status, reads the masked pending view, and clears bits by writing ones. All pending bits are combined into one interrupt line. The channel engines hold their own register contents, so this block offers no read-back of channel registers.

Top module: `dmarf_top`

## Requirements
- R1: Channel pair n (n below NUM_PAIRS) has its receive channel 2n based at n*0x40. A write at base offset 0x00, 0x04, 0x0C, 0x10, 0x14 or 0x30 raises chanWe[2n] in the same cycle. The index on chanRegIdx is 0 (descriptor address high), 1 (descriptor address low), 2 (transfer length), 3 (buffer length), 4 (receive enable) or 5 (bytes per row), in that order of offsets.
- R2: The transmit channel 2n+1 is based at n*0x40+0x18. A write at base offset 0x00, 0x04, 0x0C or 0x14 raises chanWe[2n+1] with index 0, 1, 3 or 2 respectively.
- R3: The address-control register at 0x34 keeps bit 0 of the written data. That bit drives wideAddr, reads back in bit 0, and every other bit of the register reads as zero.
- R4: The status register is at 0x080000, with bit i belonging to channel i. A done pulse on doneIn[i] sets bit i. Writing data to the status register clears every bit written as 1, so 0xFFFFFFFF clears all of them.
- R5: When a done pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: The enable register at 0x080008 stores one bit per channel and reads back as written. Bits at or above the channel count read as zero.
- R7: The pending register at 0x080004 reads as status AND enable. Writes to it change no state.
- R8: irq is high exactly when some status bit and its enable bit are both set.
- R9: Reads of undecoded addresses return zero and writes to them raise no strobe and change no state. Undecoded addresses include misaligned addresses, pairs at or beyond NUM_PAIRS, and unused offsets. Channel register addresses also read as zero.
- R10: rdData carries the value addressed by a read in the cycle after busRd is high, and is zero in the cycle after any cycle without busRd.
- R11: After reset, status, enable and address-control are zero, so irq, wideAddr and rdData are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| doneIn | input | NCH | Per-channel transfer-complete pulses |
| rdData | output | 32 | Registered read data |
| chanWe | output | NCH | One-hot channel register write strobe |
| chanRegIdx | output | 3 | Index of the channel register written |
| chanWdata | output | 32 | Write data toward the channel engines |
| irq | output | 1 | Shared interrupt |
| wideAddr | output | 1 | 32-bit addressing selected |

## Verification
The transmit offsets 0x0C and 0x14 are the easiest to get wrong. A decoder that reuses the receive ordering would give swapped indices on the length and buffer-length strobes. The bench sweeps every offset of every pair, one pair beyond the last, and misaligned neighbours. A design that decoded only the low address bits would alias those onto real channels or global registers.

A done pulse in the same cycle as a clear of that bit must leave the bit set. A design that gave the clear priority would drop the completion and irq would never rise. The bench also writes to the pending address to catch a design that lets it alias onto status or enable. It issues all-ones clears and irregular back-to-back reads to expose read data that lingers after busRd falls.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

  // Register index presented to the channel engines with each write strobe
  typedef enum logic [2:0] {
    REG_DESC_HI   = 3'd0,
    REG_DESC_LO   = 3'd1,
    REG_XFER_LEN  = 3'd2,
    REG_BUF_LEN   = 3'd3,
    REG_RX_ENABLE = 3'd4,
    REG_ROW_BYTES = 3'd5
  } chanReg_e;

  // Source selected for the registered read path
  typedef enum logic [2:0] {
    RD_NONE    = 3'd0,
    RD_STAT    = 3'd1,
    RD_PEND    = 3'd2,
    RD_EN      = 3'd3,
    RD_ADDRCTL = 3'd4
  } rdSel_e;

  // Strobes from the decoder to the global register datapath
  typedef struct packed {
    logic   wrStat;
    logic   wrEn;
    logic   wrAddrCtl;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
  import dmarf_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_PAIRS = 4,
  parameter int NCH       = 2 * NUM_PAIRS,
  parameter int GLOB_BASE = 'h80000
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output ctrlStrobes_t      ctrl,
  output logic [NCH-1:0]    chanWe,
  output logic [2:0]        chanRegIdx
);

  localparam int PAIR_SHIFT = 6;
  localparam int PAIR_W     = ADDR_W - PAIR_SHIFT;
  localparam logic [ADDR_W-1:0] STAT_ADDR    = ADDR_W'(GLOB_BASE);
  localparam logic [ADDR_W-1:0] PEND_ADDR    = ADDR_W'(GLOB_BASE + 4);
  localparam logic [ADDR_W-1:0] EN_ADDR      = ADDR_W'(GLOB_BASE + 8);
  localparam logic [ADDR_W-1:0] ADDRCTL_ADDR = ADDR_W'('h34);

  logic [PAIR_W-1:0] pairNum;
  logic [5:0]        pairOff;
  logic              inChanArea;
  logic              offHit;
  logic              isTx;
  chanReg_e          regIdx;

  assign pairNum    = busAddr[ADDR_W-1:PAIR_SHIFT];
  assign pairOff    = busAddr[PAIR_SHIFT-1:0];
  assign inChanArea = (32'(pairNum) < NUM_PAIRS);

  // Offset inside a pair -> direction and register index
  always_comb begin
    offHit = 1'b1;
    isTx   = 1'b0;
    regIdx = REG_DESC_HI;
    unique case (pairOff)
      6'h00: regIdx = REG_DESC_HI;
      6'h04: regIdx = REG_DESC_LO;
      6'h0C: regIdx = REG_XFER_LEN;
      6'h10: regIdx = REG_BUF_LEN;
      6'h14: regIdx = REG_RX_ENABLE;
      6'h30: regIdx = REG_ROW_BYTES;
      6'h18: begin isTx = 1'b1; regIdx = REG_DESC_HI;  end
      6'h1C: begin isTx = 1'b1; regIdx = REG_DESC_LO;  end
      6'h24: begin isTx = 1'b1; regIdx = REG_BUF_LEN;  end
      6'h2C: begin isTx = 1'b1; regIdx = REG_XFER_LEN; end
      default: offHit = 1'b0;
    endcase
  end

  // One strobe per channel; even = receive, odd = transmit
  for (genvar c = 0; c < NCH; c++) begin : g_chanStrobe
    assign chanWe[c] = busWr && inChanArea && offHit &&
                       (pairNum == PAIR_W'(c / 2)) && (isTx == ((c % 2) == 1));
  end

  assign chanRegIdx = regIdx;

  // Global area decode
  always_comb begin
    ctrl.wrStat    = busWr && (busAddr == STAT_ADDR);
    ctrl.wrEn      = busWr && (busAddr == EN_ADDR);
    ctrl.wrAddrCtl = busWr && (busAddr == ADDRCTL_ADDR);
    ctrl.rdSel     = RD_NONE;
    if (busRd) begin
      if (busAddr == STAT_ADDR)         ctrl.rdSel = RD_STAT;
      else if (busAddr == PEND_ADDR)    ctrl.rdSel = RD_PEND;
      else if (busAddr == EN_ADDR)      ctrl.rdSel = RD_EN;
      else if (busAddr == ADDRCTL_ADDR) ctrl.rdSel = RD_ADDRCTL;
    end
  end

endmodule

// File: rtl/dmarf_regs.sv
module dmarf_regs
  import dmarf_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobes_t   ctrl,
  input  logic [31:0]    busWdata,
  input  logic [NCH-1:0] doneIn,
  output logic [31:0]    rdData,
  output logic           irq,
  output logic           wideAddr,
  output logic [NCH-1:0] statQ,
  output logic [NCH-1:0] enQ
);

  logic [NCH-1:0] clrMask;
  logic [NCH-1:0] pendVec;
  logic           addrCtlQ;

  assign clrMask = ctrl.wrStat ? busWdata[NCH-1:0] : '0;
  assign pendVec = statQ & enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ    <= '0;
      enQ      <= '0;
      addrCtlQ <= 1'b0;
    end else begin
      // Set from a done pulse wins over a clear in the same cycle
      statQ <= (statQ & ~clrMask) | doneIn;
      if (ctrl.wrEn)      enQ      <= busWdata[NCH-1:0];
      if (ctrl.wrAddrCtl) addrCtlQ <= busWdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      unique case (ctrl.rdSel)
        RD_STAT:    rdData <= 32'(statQ);
        RD_PEND:    rdData <= 32'(pendVec);
        RD_EN:      rdData <= 32'(enQ);
        RD_ADDRCTL: rdData <= 32'(addrCtlQ);
        default:    rdData <= '0;
      endcase
    end
  end

  assign irq      = |pendVec;
  assign wideAddr = addrCtlQ;

endmodule

// File: rtl/dmarf_top.sv
module dmarf_top
  import dmarf_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_PAIRS = 4,
  parameter int GLOB_BASE = 'h80000,
  parameter int NCH       = 2 * NUM_PAIRS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [NCH-1:0]    doneIn,
  output logic [31:0]       rdData,
  output logic [NCH-1:0]    chanWe,
  output logic [2:0]        chanRegIdx,
  output logic [31:0]       chanWdata,
  output logic              irq,
  output logic              wideAddr
);

  ctrlStrobes_t   ctrl;
  logic [NCH-1:0] statQ;
  logic [NCH-1:0] enQ;

  dmarf_decode #(
    .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .NCH(NCH), .GLOB_BASE(GLOB_BASE)
  ) decode_i (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .ctrl(ctrl), .chanWe(chanWe), .chanRegIdx(chanRegIdx)
  );

  dmarf_regs #(.NCH(NCH)) regs_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busWdata(busWdata), .doneIn(doneIn),
    .rdData(rdData), .irq(irq), .wideAddr(wideAddr), .statQ(statQ), .enQ(enQ)
  );

  assign chanWdata = busWdata;

endmodule

// File: rtl/dmarf_chk.sv
module dmarf_chk #(
  parameter int ADDR_W    = 20,
  parameter int NCH       = 8,
  parameter int GLOB_BASE = 'h80000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busWr,
  input logic              busRd,
  input logic [NCH-1:0]    doneIn,
  input logic [31:0]       rdData,
  input logic [NCH-1:0]    chanWe,
  input logic              irq,
  input logic [NCH-1:0]    statQ
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(GLOB_BASE);

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanWe));

  // R9
  strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanWe != '0) |-> busWr);

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> (rdData == '0));

  // R5
  done_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn != '0) |=> ((statQ & $past(doneIn)) == $past(doneIn)));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == STAT_ADDR && doneIn == '0)
      |=> ((statQ & $past(busWdata[NCH-1:0])) == '0));

  // R8
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statQ != '0));

endmodule

bind dmarf_top dmarf_chk #(.ADDR_W(ADDR_W), .NCH(NCH), .GLOB_BASE(GLOB_BASE)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
  .busRd(busRd), .doneIn(doneIn), .rdData(rdData), .chanWe(chanWe), .irq(irq),
  .statQ(statQ)
);

// File: tb/dmarf_top_tb_top.sv
module dmarf_top_tb_top;

  localparam int ADDR_W = 20;
  localparam int NPAIR  = 4;
  localparam int NCH    = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic              busWr = 1'b0;
  logic              busRd = 1'b0;
  logic [NCH-1:0]    doneIn = '0;
  logic [31:0]       rdData;
  logic [NCH-1:0]    chanWe;
  logic [2:0]        chanRegIdx;
  logic [31:0]       chanWdata;
  logic              irq;
  logic              wideAddr;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dmarf_top #(.ADDR_W(ADDR_W), .NUM_PAIRS(NPAIR)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .doneIn(doneIn), .rdData(rdData),
    .chanWe(chanWe), .chanRegIdx(chanRegIdx), .chanWdata(chanWdata),
    .irq(irq), .wideAddr(wideAddr)
  );

  // Reference model state
  logic [NCH-1:0] mStat, mEn;
  logic           mAcr;
  logic [31:0]    mRd;

  function automatic logic [31:0] refRead(int a);
    case (a)
      'h80000: return 32'(mStat);
      'h80004: return 32'(mStat & mEn);
      'h80008: return 32'(mEn);
      'h34:    return 32'(mAcr);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [NCH-1:0] clr;
    if (!rstN) begin
      mStat <= '0; mEn <= '0; mAcr <= 1'b0; mRd <= '0;
    end else begin
      clr = (busWr && busAddr == 'h80000) ? busWdata[NCH-1:0] : '0;
      mStat <= (mStat & ~clr) | doneIn;
      if (busWr && busAddr == 'h80008) mEn <= busWdata[NCH-1:0];
      if (busWr && busAddr == 'h34) mAcr <= busWdata[0];
      mRd <= busRd ? refRead(int'(busAddr)) : 32'h0;
    end
  end

  // Expected channel strobe from the address map in R1/R2/R9
  task automatic refStrobe(output logic [NCH-1:0] we, output int idx);
    int a, pair, off, ch;
    we = '0; idx = 0; ch = -1;
    a = int'(busAddr);
    pair = a / 64; off = a % 64;
    if (busWr && (a % 4 == 0) && pair < NPAIR) begin
      case (off)
        'h00: begin ch = 2*pair;   idx = 0; end
        'h04: begin ch = 2*pair;   idx = 1; end
        'h0C: begin ch = 2*pair;   idx = 2; end
        'h10: begin ch = 2*pair;   idx = 3; end
        'h14: begin ch = 2*pair;   idx = 4; end
        'h30: begin ch = 2*pair;   idx = 5; end
        'h18: begin ch = 2*pair+1; idx = 0; end
        'h1C: begin ch = 2*pair+1; idx = 1; end
        'h24: begin ch = 2*pair+1; idx = 3; end
        'h2C: begin ch = 2*pair+1; idx = 2; end
        default: ch = -1;
      endcase
    end
    if (ch >= 0) we[ch] = 1'b1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [NCH-1:0] we;
    int idx;
    refStrobe(we, idx);
    check("R1 R2 R9 strobe", 32'(chanWe), 32'(we));
    if (we != '0) check("R1 R2 index", 32'(chanRegIdx), 32'(idx));
    check("R3 R4 R6 R7 R9 R10 rdData", rdData, mRd);
    check("R5 R8 irq", 32'(irq), 32'(|(mStat & mEn)));
    check("R3 wideAddr", 32'(wideAddr), 32'(mAcr));
  endtask

  task automatic cyc(int a, logic [31:0] d, bit wr, bit rd, logic [NCH-1:0] dn);
    @(negedge clk);
    busAddr = ADDR_W'(a); busWdata = d; busWr = wr; busRd = rd; doneIn = dn;
    #2;
    compareAll();
  endtask

  task automatic wr(int a, logic [31:0] d); cyc(a, d, 1'b1, 1'b0, '0); endtask
  task automatic rd(int a);                 cyc(a, 32'h0, 1'b0, 1'b1, '0); endtask
  task automatic idle();                    cyc(0, 32'h0, 1'b0, 1'b0, '0); endtask

  int addrList[$];

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    // R11 reset state
    check("R11 rdData", rdData, 32'h0);
    check("R11 irq", 32'(irq), 32'h0);
    check("R11 wideAddr", 32'(wideAddr), 32'h0);

    // R3 address control
    wr('h34, 32'hFFFF_FFFF); rd('h34); idle();
    wr('h34, 32'h0000_0002); rd('h34); idle();
    wr('h34, 32'h1); rd('h34);

    // R1 R2 R9 every offset of every pair plus one extra pair
    for (int p = 0; p <= NPAIR; p++)
      for (int o = 0; o < 64; o += 2) begin
        wr(p*64 + o, 32'hA5A5_0000 + 32'(o));
        check("R9 chanWdata", chanWdata, 32'hA5A5_0000 + 32'(o));
      end
    for (int p = 0; p < NPAIR; p++) rd(p*64 + 'h14);

    // R6 R7 R8 R4 R5
    wr('h80008, 32'hFFFF_FFFF); rd('h80008);
    cyc(0, 0, 0, 0, 8'h08); idle(); rd('h80004); rd('h80000);
    wr('h80004, 32'hFFFF_FFFF); rd('h80000); rd('h80004);
    wr('h80000, 32'h0000_0008); rd('h80000);
    cyc('h80000, 32'h10, 1, 0, 8'h10); rd('h80000);
    cyc(0, 0, 0, 0, 8'hFF); wr('h80000, 32'hFFFF_FFFF); rd('h80000);
    cyc(0, 0, 0, 0, 8'h41); wr('h80008, 32'h01); rd('h80004);
    wr('h80008, 32'h00); rd('h80004); idle();
    wr('h80001, 32'hFF); wr('h80010, 32'hFF); rd('h80008); rd('h80003); rd('h35);

    // Mixed traffic
    for (int p = 0; p <= NPAIR; p++)
      for (int o = 0; o < 64; o += 4) addrList.push_back(p*64 + o);
    addrList.push_back('h80000); addrList.push_back('h80004);
    addrList.push_back('h80008); addrList.push_back('h8000C);
    addrList.push_back('h80000); addrList.push_back('h80008);
    addrList.push_back('h36);
    for (int i = 0; i < 3000; i++) begin
      int a;
      logic [31:0] d;
      logic [NCH-1:0] dn;
      a  = addrList[$urandom_range(0, addrList.size() - 1)];
      d  = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : $urandom;
      dn = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
      cyc(a, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), dn);
    end
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule